// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one I2C master transaction at the level of bytes and bus conditions. Software or a higher-level controller places a packed command word on `cmd_i` and pulses `go_i`. The sequencer then asks a separate bit engine for a START, an optional start-byte preamble, the address byte or bytes (7-bit or 10-bit), the data bytes and a closing STOP. Instead of the STOP it can also leave the bus held so that the next command opens with a repeated START. Write data comes from a show-ahead TX FIFO and read data goes to an RX FIFO.

When a transaction ends, the sequencer pulses one of three outcome signals and updates a status word. The status word holds the operation, the controller state, a coded abort cause and the number of bytes transferred. Timing on SCL/SDA belongs to the bit engine. The engine takes one request at a time: it sees `be_req_o` with an op code and answers with a single-cycle `be_done_i`. At any point it may instead report lost arbitration or a bus error.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A `go_i` pulse while idle latches `cmd_i` and the next request is a START (op code 0). A `go_i` pulse while a transaction is in progress is ignored.
- R2: When the address mode field (bits 13:12) is not 2, one address byte `{cmd[7:1], cmd[0]}` is sent, where bit 0 is the direction (1 = read).
- R3: Address mode 2 selects 10-bit addressing with the address `{cmd[10:8], cmd[7:1]}`. The first byte is `{5'b11110, addr[9:8], dir}` and the second byte is `addr[7:0]`.
- R4: With bit 11 set, the START is followed by a written byte 0x01 and then by a second START before the address. The acknowledge on the 0x01 byte is ignored.
- R5: A write sends `cmd[25:15]` bytes in TX FIFO order. `tx_pop_o` fires only while the FIFO is not empty, and the sequencer waits with no request while the FIFO is empty.
- R6: A read issues read requests (op code 3) with `be_ack_o`=1 for every byte except the last, which has `be_ack_o`=0. Each returned byte is pushed on `rx_push_o` in the cycle of its `be_done_i`.
- R7: With bit 14 set, a STOP (op code 1) is requested after the last byte, followed by `done_o`. With bit 14 clear, no STOP is issued and `done_nostop_o` pulses. Exactly one outcome pulse marks each end.
- R8: A byte count of zero ends the transaction right after the address phase, with no data request.
- R9: `status_o` holds the operation in [1:0] (3 after reset), the state in [3:2] (0 idle, 1 busy, 2 ok, 3 abort), the abort cause in [6:4], zero in [8:7] and the count of acknowledged or received bytes in [19:9].
- R10: A missing acknowledge on an address byte aborts with cause 0, and one on a data byte aborts with cause 1. In both cases a STOP follows and then `abort_o` pulses.
- R11: Lost arbitration (cause 3) or a bus error (cause 4) at any point of a transaction aborts at once, returns to idle with no STOP and pulses `abort_o`.
- R12: A request holds its op code and write byte steady until it is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 26 | Packed transaction command |
| go_i | input | 1 | Start strobe, taken while idle |
| be_req_o | output | 1 | Request pending to the bit engine |
| be_op_o | output | 2 | Request op: 0 START, 1 STOP, 2 write byte, 3 read byte |
| be_wdata_o | output | 8 | Byte to transmit on a write request |
| be_ack_o | output | 1 | Acknowledge to return after a read byte (1 = ack) |
| be_done_i | input | 1 | Request finished (single cycle) |
| be_ack_i | input | 1 | Slave acknowledged the written byte |
| be_rdata_i | input | 8 | Byte received on a read request |
| be_arb_lost_i | input | 1 | Arbitration lost event |
| be_bus_err_i | input | 1 | Misplaced START/STOP event |
| tx_data_i | input | 8 | Head of the TX FIFO |
| tx_empty_i | input | 1 | TX FIFO empty |
| tx_pop_o | output | 1 | Take the head of the TX FIFO |
| rx_data_o | output | 8 | Byte for the RX FIFO |
| rx_push_o | output | 1 | Push rx_data_o |
| done_o | output | 1 | Finished with STOP |
| done_nostop_o | output | 1 | Finished with the bus held |
| abort_o | output | 1 | Finished by abort |
| status_o | output | 20 | Status word |

## Verification
The hardest cases to reach are the ones that end a transaction early, in one particular phase. Examples are a lost arbitration on the second data byte, a bus error during the upper 10-bit address byte, and a missing acknowledge on a middle data byte. In each case the byte count and the remaining TX FIFO contents must match where the transaction stopped. The bench's bit-engine model answers requests after a varying delay and can inject an event or a missing acknowledge at a chosen request index. The expected request list is cut at that same point, so any extra request, missing STOP or wrong count shows up as a mismatch. A TX FIFO that is refilled only after the transaction has started exercises the stall path.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } be_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SBYTE, S_SRST, S_ADDR1, S_ADDR2,
    S_WLOAD, S_WRITE, S_READ, S_STOP
  } seq_state_e;

  localparam logic [1:0] CTL_IDLE  = 2'd0;
  localparam logic [1:0] CTL_BUSY  = 2'd1;
  localparam logic [1:0] CTL_OK    = 2'd2;
  localparam logic [1:0] CTL_ABORT = 2'd3;

  localparam logic [2:0] CAUSE_ADDR_NACK = 3'd0;
  localparam logic [2:0] CAUSE_DATA_NACK = 3'd1;
  localparam logic [2:0] CAUSE_ARB_LOST  = 3'd3;
  localparam logic [2:0] CAUSE_BUS_ERR   = 3'd4;

  localparam logic [7:0] START_BYTE = 8'h01;

endpackage

// File: rtl/i2c_cmd_seq_dec.sv
module i2c_cmd_seq_dec #(
  parameter int LEN_W = 11,
  localparam int CMD_W = 15 + LEN_W
) (
  input  logic [CMD_W-1:0] cmd_i,
  output logic             rd_o,
  output logic             ten_o,
  output logic             sb_o,
  output logic             stop_o,
  output logic [9:0]       addr_o,
  output logic [LEN_W-1:0] len_o
);
  assign rd_o   = cmd_i[0];
  assign ten_o  = (cmd_i[13:12] == 2'd2);
  assign sb_o   = cmd_i[11];
  assign stop_o = cmd_i[14];
  // 7-bit mode uses only the low seven bits
  assign addr_o = {cmd_i[10:8], cmd_i[7:1]};
  assign len_o  = cmd_i[CMD_W-1:15];
endmodule

// File: rtl/i2c_cmd_seq_addr.sv
module i2c_cmd_seq_addr (
  input  logic       ten_i,
  input  logic       rd_i,
  input  logic [9:0] addr_i,
  output logic [7:0] first_o,
  output logic [7:0] second_o
);
  always_comb begin
    if (ten_i) first_o = {5'b11110, addr_i[9:8], rd_i};
    else       first_o = {addr_i[6:0], rd_i};
  end
  assign second_o = addr_i[7:0];
endmodule

// File: rtl/i2c_cmd_seq_cnt.sv
module i2c_cmd_seq_cnt #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [LEN_W:0] ONE_W = (LEN_W+1)'(1);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + LEN_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (({1'b0, cnt_q} + ONE_W) == {1'b0, len_i});
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_seq_pkg::*;
#(
  parameter int LEN_W = 11,
  localparam int CMD_W = 15 + LEN_W,
  localparam int ST_W  = 9 + LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             go_i,
  output logic             be_req_o,
  output logic [1:0]       be_op_o,
  output logic [7:0]       be_wdata_o,
  output logic             be_ack_o,
  input  logic             be_done_i,
  input  logic             be_ack_i,
  input  logic [7:0]       be_rdata_i,
  input  logic             be_arb_lost_i,
  input  logic             be_bus_err_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_empty_i,
  output logic             tx_pop_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_push_o,
  output logic             done_o,
  output logic             done_nostop_o,
  output logic             abort_o,
  output logic [ST_W-1:0]  status_o
);

  seq_state_e       state_q, state_d, fin_state, after_addr;
  logic             dec_rd, dec_ten, dec_sb, dec_stop;
  logic [9:0]       dec_addr;
  logic [LEN_W-1:0] dec_len;
  logic             rd_q, ten_q, sb_q, stop_q;
  logic [9:0]       addr_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [7:0]       wbyte_q, abyte1, abyte2;
  logic [1:0]       ctl_q, op_q;
  logic [2:0]       cause_q, nack_cause;
  logic             pend_abort_q, done_q, nostop_q, abt_q;
  logic             evt, launch, nack, cnt_inc, last, fin_ns, stop_end;

  i2c_cmd_seq_dec #(.LEN_W(LEN_W)) u_dec (
    .cmd_i(cmd_i), .rd_o(dec_rd), .ten_o(dec_ten), .sb_o(dec_sb),
    .stop_o(dec_stop), .addr_o(dec_addr), .len_o(dec_len)
  );

  i2c_cmd_seq_addr u_addr (
    .ten_i(ten_q), .rd_i(rd_q), .addr_i(addr_q),
    .first_o(abyte1), .second_o(abyte2)
  );

  i2c_cmd_seq_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(launch), .inc_i(cnt_inc),
    .len_i(len_q), .cnt_o(cnt), .last_o(last)
  );

  assign evt        = (state_q != S_IDLE) && (be_arb_lost_i || be_bus_err_i);
  assign fin_state  = stop_q ? S_STOP : S_IDLE;
  assign after_addr = (len_q == '0) ? fin_state : (rd_q ? S_READ : S_WLOAD);

  always_comb begin
    state_d    = state_q;
    launch     = 1'b0;
    nack       = 1'b0;
    nack_cause = CAUSE_ADDR_NACK;
    cnt_inc    = 1'b0;
    tx_pop_o   = 1'b0;
    rx_push_o  = 1'b0;
    if (evt) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE:  if (go_i) begin launch = 1'b1; state_d = S_START; end
        S_START: if (be_done_i) state_d = sb_q ? S_SBYTE : S_ADDR1;
        S_SBYTE: if (be_done_i) state_d = S_SRST;
        S_SRST:  if (be_done_i) state_d = S_ADDR1;
        S_ADDR1, S_ADDR2: if (be_done_i) begin
          if (!be_ack_i) begin
            nack = 1'b1;
            state_d = S_STOP;
          end else if (state_q == S_ADDR1 && ten_q) begin
            state_d = S_ADDR2;
          end else begin
            state_d = after_addr;
          end
        end
        S_WLOAD: if (!tx_empty_i) begin tx_pop_o = 1'b1; state_d = S_WRITE; end
        S_WRITE: if (be_done_i) begin
          if (!be_ack_i) begin
            nack = 1'b1;
            nack_cause = CAUSE_DATA_NACK;
            state_d = S_STOP;
          end else begin
            cnt_inc = 1'b1;
            state_d = last ? fin_state : S_WLOAD;
          end
        end
        S_READ: if (be_done_i) begin
          rx_push_o = 1'b1;
          cnt_inc   = 1'b1;
          state_d   = last ? fin_state : S_READ;
        end
        S_STOP:  if (be_done_i) state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign stop_end = (state_q == S_STOP) && be_done_i && !evt;
  // only path into idle that is neither an event nor a finished STOP
  assign fin_ns   = (state_d == S_IDLE) && (state_q != S_IDLE) && (state_q != S_STOP) && !evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      rd_q         <= 1'b0;
      ten_q        <= 1'b0;
      sb_q         <= 1'b0;
      stop_q       <= 1'b0;
      addr_q       <= '0;
      len_q        <= '0;
      wbyte_q      <= '0;
      ctl_q        <= CTL_IDLE;
      op_q         <= 2'd3;
      cause_q      <= '0;
      pend_abort_q <= 1'b0;
      done_q       <= 1'b0;
      nostop_q     <= 1'b0;
      abt_q        <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= 1'b0;
      nostop_q <= 1'b0;
      abt_q    <= 1'b0;
      if (launch) begin
        rd_q         <= dec_rd;
        ten_q        <= dec_ten;
        sb_q         <= dec_sb;
        stop_q       <= dec_stop;
        addr_q       <= dec_addr;
        len_q        <= dec_len;
        op_q         <= {1'b0, dec_rd};
        ctl_q        <= CTL_BUSY;
        cause_q      <= '0;
        pend_abort_q <= 1'b0;
      end
      if (tx_pop_o) wbyte_q <= tx_data_i;
      if (nack) begin
        pend_abort_q <= 1'b1;
        cause_q      <= nack_cause;
      end
      if (evt) begin
        ctl_q        <= CTL_ABORT;
        cause_q      <= be_arb_lost_i ? CAUSE_ARB_LOST : CAUSE_BUS_ERR;
        abt_q        <= 1'b1;
        pend_abort_q <= 1'b0;
      end
      if (stop_end) begin
        ctl_q  <= pend_abort_q ? CTL_ABORT : CTL_OK;
        abt_q  <= pend_abort_q;
        done_q <= !pend_abort_q;
      end
      if (fin_ns) begin
        ctl_q    <= CTL_OK;
        nostop_q <= 1'b1;
      end
    end
  end

  always_comb begin
    be_req_o   = 1'b1;
    be_op_o    = OP_WRITE;
    be_wdata_o = wbyte_q;
    unique case (state_q)
      S_START, S_SRST: be_op_o = OP_START;
      S_SBYTE: be_wdata_o = START_BYTE;
      S_ADDR1: be_wdata_o = abyte1;
      S_ADDR2: be_wdata_o = abyte2;
      S_WRITE: be_wdata_o = wbyte_q;
      S_READ:  be_op_o = OP_READ;
      S_STOP:  be_op_o = OP_STOP;
      default: be_req_o = 1'b0;
    endcase
  end

  assign be_ack_o      = !last;
  assign rx_data_o     = be_rdata_i;
  assign done_o        = done_q;
  assign done_nostop_o = nostop_q;
  assign abort_o       = abt_q;
  assign status_o      = {cnt, 2'b00, cause_q, ctl_q, op_q};

endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
  import i2c_cmd_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        be_req_o,
  input logic [1:0]  be_op_o,
  input logic [7:0]  be_wdata_o,
  input logic        be_done_i,
  input logic        be_arb_lost_i,
  input logic        be_bus_err_i,
  input logic        tx_empty_i,
  input logic        tx_pop_o,
  input logic        rx_push_o,
  input logic        done_o,
  input logic        done_nostop_o,
  input logic        abort_o,
  input logic [19:0] status_o
);

  p_one_outcome_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, done_nostop_o, abort_o}));

  p_done_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o[3:2] == CTL_OK) && $past(be_req_o && be_op_o == OP_STOP && be_done_i));

  p_nostop_no_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_nostop_o |-> (status_o[3:2] == CTL_OK) && !$past(be_req_o && be_op_o == OP_STOP));

  p_req_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_o && !be_done_i && !be_arb_lost_i && !be_bus_err_i)
      |=> be_req_o && $stable(be_op_o) && $stable(be_wdata_o));

  p_pop_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);

  p_push_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> be_req_o && be_op_o == OP_READ && be_done_i);

  p_arb_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_arb_lost_i && be_req_o)
      |=> abort_o && status_o[6:4] == CAUSE_ARB_LOST && !be_req_o);

  p_abort_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> status_o[3:2] == CTL_ABORT);

endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .be_req_o(be_req_o), .be_op_o(be_op_o),
  .be_wdata_o(be_wdata_o), .be_done_i(be_done_i), .be_arb_lost_i(be_arb_lost_i),
  .be_bus_err_i(be_bus_err_i), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o),
  .rx_push_o(rx_push_o), .done_o(done_o), .done_nostop_o(done_nostop_o),
  .abort_o(abort_o), .status_o(status_o)
);

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] cmd = '0;
  logic        go = 1'b0;
  logic        req, mack, pop, push, d_stop, d_nostop, d_abort;
  logic [1:0]  op;
  logic [7:0]  wdat, rxd;
  logic        done_in = 1'b0, sack = 1'b0, arb = 1'b0, berr = 1'b0;
  logic [7:0]  rdat = '0, txd = '0;
  logic        txe = 1'b1;
  logic [19:0] st;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .go_i(go),
    .be_req_o(req), .be_op_o(op), .be_wdata_o(wdat), .be_ack_o(mack),
    .be_done_i(done_in), .be_ack_i(sack), .be_rdata_i(rdat),
    .be_arb_lost_i(arb), .be_bus_err_i(berr),
    .tx_data_i(txd), .tx_empty_i(txe), .tx_pop_o(pop),
    .rx_data_o(rxd), .rx_push_o(push),
    .done_o(d_stop), .done_nostop_o(d_nostop), .abort_o(d_abort), .status_o(st)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // expected bit-engine requests
  int          e_op[$];
  int          e_dat[$];
  int          e_flg[$];   // 0 ack, 1 nack, 2 arbitration lost, 3 bus error
  int          e_rd[$];
  string       e_tag[$];
  logic [7:0]  tx_q[$];

  int b_k, b_evt_at, b_cause;
  bit b_berr, b_ended;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit add(int o, int d, int r, string t);
    int f;
    if (b_ended) return 1'b0;
    f = 0;
    if (b_k == b_evt_at) begin
      f = b_berr ? 3 : 2;
      b_ended = 1'b1;
      b_cause = b_berr ? 4 : 3;
    end
    e_op.push_back(o);
    e_dat.push_back(d);
    e_flg.push_back(f);
    e_rd.push_back(r);
    e_tag.push_back(t);
    b_k++;
    return f == 0;
  endfunction

  // bit-engine and FIFO model, cycle by cycle
  initial begin : responder
    int wc, oc, sop, sdat, eo, ed, ef, er;
    bit pp;
    string t;
    wc = 0; oc = 0; pp = 1'b0; sop = 0; sdat = 0;
    forever begin
      @(negedge clk);
      done_in = 1'b0; arb = 1'b0; berr = 1'b0;
      if (pp) begin void'(tx_q.pop_front()); pp = 1'b0; end
      txe = (tx_q.size() == 0);
      txd = txe ? 8'h00 : tx_q[0];
      #1;
      if (pop) pp = 1'b1;
      if (push) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 stray rx push act=1 exp=0");
      end
      if (req && rst_n) begin
        if (wc == 0) begin
          sop = int'(op); sdat = int'(wdat);
        end else begin
          chk("R12 op held", int'(op), sop);
          chk("R12 byte held", int'(wdat), sdat);
        end
        wc++;
        if (wc >= 1 + oc % 3) begin
          wc = 0; oc++;
          if (e_op.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 unexpected request act=%0d exp=none", int'(op));
            done_in = 1'b1; sack = 1'b1;
          end else begin
            eo = e_op.pop_front(); ed = e_dat.pop_front(); ef = e_flg.pop_front();
            er = e_rd.pop_front(); t = e_tag.pop_front();
            chk({t, " op"}, int'(op), eo);
            if (eo == 2) chk({t, " byte"}, int'(wdat), ed);
            if (eo == 3) chk({t, " R6 master ack"}, int'(mack), ed);
            if (ef == 2) arb = 1'b1;
            else if (ef == 3) berr = 1'b1;
            else begin
              done_in = 1'b1; sack = (ef != 1); rdat = er[7:0];
            end
            if (eo == 3 && ef == 0) begin
              #1;
              chk({t, " R6 push"}, int'(push), 1);
              chk({t, " R6 rx byte"}, int'(rxd), er);
            end
          end
        end
      end else begin
        wc = 0;
      end
    end
  end

  task automatic run(string nm, bit rd, int mode, bit sb, bit stp, int len, int addr,
                     int nack_at, int evt_at, bit be, bit busy_go, bit late);
    bit ten, nk, seen, was, ok;
    int b1, ecause, elen, kind, cyc, act, rv, wv;
    logic [7:0] late_q[$];
    logic [25:0] c;
    string kt;
    ten = (mode == 2);
    b_k = 0; b_evt_at = evt_at; b_berr = be; b_ended = 1'b0; b_cause = 0;
    nk = 1'b0; elen = 0; ecause = 0;
    void'(add(0, 0, 0, "R1 start"));
    if (sb) begin
      void'(add(2, 1, 0, "R4 start byte"));
      void'(add(0, 0, 0, "R4 restart"));
    end
    b1 = ten ? int'({5'b11110, addr[9:8], rd}) : int'({addr[6:0], rd});
    if (add(2, b1, 0, ten ? "R3 first addr" : "R2 addr") && nack_at == -1) begin
      e_flg[e_flg.size()-1] = 1; nk = 1'b1; ecause = 0;
    end
    if (ten && !nk) void'(add(2, addr & 255, 0, "R3 second addr"));
    for (int j = 0; j < len && !nk; j++) begin
      if (rd) begin
        rv = (8'h3C + j * 7) & 255;
        if (add(3, (j == len - 1) ? 0 : 1, rv, "R6 read")) elen = j + 1;
      end else begin
        wv = (8'h90 + j + len) & 255;
        was = !b_ended;
        ok = add(2, wv, 0, "R5 write");
        if (was) begin
          if (late) late_q.push_back(wv[7:0]);
          else tx_q.push_back(wv[7:0]);
        end
        if (ok) begin
          if (j == nack_at) begin
            e_flg[e_flg.size()-1] = 1; nk = 1'b1; ecause = 1;
          end else begin
            elen = j + 1;
          end
        end
      end
    end
    if (nk || stp) void'(add(1, 0, 0, nk ? "R10 stop after nack" : "R7 stop"));
    if (b_ended) begin kind = 2; ecause = b_cause; end
    else if (nk) kind = 2;
    else kind = stp ? 0 : 1;

    c = '0;
    c[0] = rd;
    c[7:1] = addr[6:0];
    c[10:8] = ten ? addr[9:7] : 3'b000;
    c[11] = sb;
    c[13:12] = mode[1:0];
    c[14] = stp;
    c[25:15] = len[10:0];
    @(negedge clk);
    cmd = c; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    cyc = 0; seen = 1'b0;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      #2;
      cyc++;
      if (busy_go && cyc == 3) begin cmd = c ^ 26'h0007FFE; go = 1'b1; end
      if (busy_go && cyc == 4) go = 1'b0;
      if (late && cyc == 25) while (late_q.size() > 0) tx_q.push_back(late_q.pop_front());
      if (d_stop || d_nostop || d_abort) seen = 1'b1;
    end
    act = d_stop ? 0 : d_nostop ? 1 : d_abort ? 2 : 9;
    kt = (kind == 2) ? ((ecause >= 3) ? "R11 outcome" : "R10 outcome") : "R7 outcome";
    chk({nm, " ", kt}, act, kind);
    chk({nm, " R9 op field"}, int'(st[1:0]), int'(rd));
    chk({nm, " R9 state field"}, int'(st[3:2]), (kind == 2) ? 3 : 2);
    if (kind == 2) chk({nm, (ecause >= 3) ? " R11 cause" : " R10 cause"}, int'(st[6:4]), ecause);
    chk({nm, " R9 type field"}, int'(st[8:7]), 0);
    chk({nm, " R9 length"}, int'(st[19:9]), elen);
    chk({nm, " R8 all requests issued"}, e_op.size(), 0);
    chk({nm, " R5 tx fifo drained"}, tx_q.size(), 0);
    e_op.delete(); e_dat.delete(); e_flg.delete(); e_rd.delete(); e_tag.delete();
    repeat (3) @(negedge clk);
    #2;
    chk({nm, " R11 idle after end"}, int'(req), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset status", int'(st), 3);
    chk("R1 reset no request", int'(req), 0);
    chk("R7 reset no outcome", int'({d_stop, d_nostop, d_abort}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    //   name              rd mode sb stp len addr    nack evt be bg late
    run("w7 three",        0, 1,   0, 1,  3,  10'h05A, -2, -1, 0, 0, 0);
    run("r7 four",         1, 1,   0, 1,  4,  10'h033, -2, -1, 0, 0, 0);
    run("w10 two",         0, 2,   0, 1,  2,  10'h2C5, -2, -1, 0, 0, 0);
    run("r10 nostop",      1, 2,   0, 0,  2,  10'h17E, -2, -1, 0, 0, 0);
    run("r7 one restart",  1, 1,   0, 1,  1,  10'h011, -2, -1, 0, 0, 0);
    run("w zero R8",       0, 1,   0, 1,  0,  10'h044, -2, -1, 0, 0, 0);
    run("r zero nostop",   1, 1,   0, 0,  0,  10'h045, -2, -1, 0, 0, 0);
    run("start byte R4",   0, 1,   1, 1,  1,  10'h022, -2, -1, 0, 0, 0);
    run("mode3 as 7b R2",  0, 3,   0, 1,  1,  10'h07F, -2, -1, 0, 0, 0);
    run("addr nack",       0, 1,   0, 1,  2,  10'h066, -1, -1, 0, 0, 0);
    run("data nack",       0, 1,   0, 0,  3,  10'h067, 1,  -1, 0, 0, 0);
    run("arb lost",        0, 1,   0, 1,  3,  10'h068, -2, 3,  0, 0, 0);
    run("bus error",       1, 2,   0, 1,  2,  10'h3A1, -2, 1,  1, 0, 0);
    run("busy go R1",      0, 1,   0, 1,  4,  10'h070, -2, -1, 0, 1, 0);
    run("tx stall",        0, 1,   0, 1,  3,  10'h071, -2, -1, 0, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule